// File: doc/BRIEF.md
# Debug Mode Entry and Control Register Controller

This block manages Debug Mode for one RISC-V hart. It holds the debug control/status register (CSR address 0x7B0, 32 bits) and the debug PC register (CSR address 0x7B1, XLEN bits). It watches the halt sources that can fire in any cycle and picks one of them by a fixed priority. On entry it records the cause, the privilege level, the virtualization mode and the PC of the next instruction. When the debugger asks to resume, it hands those values back to the hart.

The halt sources are a critical error, a reset-halt request, a halt-group event, a halt request, a trigger hit, an ebreak and a completed single step. The debugger reaches both registers through a simple read/write port. The block drives a debug-mode flag, a one-cycle resume pulse with the resume PC, privilege and virtualization mode, a critical-error signal for the platform, an ebreak-as-exception flag, an interrupt mask, and the counter-freeze and time-freeze controls. Entry is registered: a halt source seen in one cycle shows as Debug Mode after the next rising clock edge.

Top module: `dbg_mode_ctrl`

## Requirements
- R1: After reset the block is out of Debug Mode, resume_o is low and irq_mask_o is low. Reading the control register at 0x7B0 returns 0x40000003, which is version 4 in bits 31:28 and privilege 3 in bits 1:0, with the cause, extended cause and cetrig fields at 0.
- R2: When several halt sources arrive in the same cycle outside Debug Mode, the block records one cause code in bits 8:6. The ranking from highest to lowest is: reset-halt (code 5), halt group (6), halt request (3), trigger (2), ebreak (1), step (4).
- R3: If bit 19 (cetrig) is 1, a critical error enters Debug Mode with cause 7. This outranks every other source, the extended cause in bits 26:24 reads 0, and crit_err_o stays low.
- R4: If bit 19 is 0, a critical error raises crit_err_o in that cycle and does not enter Debug Mode.
- R5: On entry, bits 1:0 capture cur_priv_i, bit 5 captures cur_virt_i, and the debug PC captures next_pc_i.
- R6: A resume request in Debug Mode leaves Debug Mode after the next edge. In that cycle resume_o pulses high for exactly one cycle, with resume_pc_o equal to the debug PC and resume_priv_o and resume_virt_o equal to bits 1:0 and bit 5.
- R7: A resume request made while the cause is 7 and bit 19 is still 1 keeps the hart in Debug Mode with no resume pulse.
- R8: An ebreak enters Debug Mode (cause 1) only if the enable bit for the current mode is set: M = bit 15, S = bit 13, U = bit 12, VS = bit 17, VU = bit 16. Otherwise ebreak_exc_o is high and the hart does not halt.
- R9: With bit 2 (step) set outside Debug Mode, step_done_i halts the hart with cause 4. irq_mask_o is high in Debug Mode, and also while step is set and bit 11 (step interrupt enable) is 0.
- R10: Bit 3 of the control register reads the live nmi_pend_i input.
- R11: A debugger write of an unsupported privilege value (2, or a mode not configured) to bits 1:0 reads back as 3.
- R12: Writes and captures of the debug PC force bit 0 to zero, and bit 1 as well when the instruction alignment is 32.
- R13: Debugger writes leave the cause (8:6), extended cause (26:24) and version (31:28) fields unchanged. All writable fields read back what was written.
- R14: In Debug Mode, new halt sources do not change the cause. stop_count_o and stop_time_o equal bit 10 and bit 9 in Debug Mode, and are 0 outside it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt_crit_i | input | 1 | Critical error present |
| halt_rst_i | input | 1 | Halt-out-of-reset request |
| halt_grp_i | input | 1 | Halt-group event |
| halt_req_i | input | 1 | Debugger halt request |
| trig_i | input | 1 | Trigger hit requesting Debug Mode |
| ebreak_i | input | 1 | ebreak executed this cycle |
| step_done_i | input | 1 | One instruction retired |
| cur_priv_i | input | 2 | Current privilege level |
| cur_virt_i | input | 1 | Current virtualization mode |
| next_pc_i | input | XLEN | Address of next instruction |
| nmi_pend_i | input | 1 | NMI pending |
| resume_req_i | input | 1 | Debugger resume request |
| csr_we_i | input | 1 | Debugger write strobe |
| csr_addr_i | input | 12 | Debugger CSR address |
| csr_wdata_i | input | XLEN | Debugger write data |
| csr_rdata_o | output | XLEN | Read data for csr_addr_i |
| debug_mode_o | output | 1 | Hart is in Debug Mode |
| resume_o | output | 1 | One-cycle resume pulse |
| resume_pc_o | output | XLEN | PC to resume at |
| resume_priv_o | output | 2 | Privilege to resume in |
| resume_virt_o | output | 1 | Virtualization mode to resume in |
| crit_err_o | output | 1 | Critical error signalled to the platform |
| ebreak_exc_o | output | 1 | ebreak taken as an ordinary exception |
| irq_mask_o | output | 1 | Mask interrupts including NMI |
| stop_count_o | output | 1 | Freeze hart-local counters |
| stop_time_o | output | 1 | Freeze the time view |

## Verification
Some properties are checked by assertions on every cycle:
- at most one granted halt source,
- a legal stored privilege,
- an aligned debug PC,
- an unchanged cause across writes and across new sources while halted,
- capture of privilege and PC on entry,
- cause 7 after an enabled critical error,
- no exit while critical re-entry applies.

Other behaviour needs the bench scenarios: the exact ranking across mixed source patterns, the per-mode ebreak gating, the readback values of every field, the live NMI bit, the interrupt mask under the step settings, and the resume pulse width and values.

// File: rtl/dbg_ctrl_pkg.sv
package dbg_ctrl_pkg;

  localparam logic [11:0] ADDR_DCTL = 12'h7B0;
  localparam logic [11:0] ADDR_DPC  = 12'h7B1;
  localparam logic [3:0]  DBG_VERSION = 4'd4;

  // control register bit positions
  localparam int B_CETRIG = 19;
  localparam int B_EB_VS  = 17;
  localparam int B_EB_VU  = 16;
  localparam int B_EB_M   = 15;
  localparam int B_EB_S   = 13;
  localparam int B_EB_U   = 12;
  localparam int B_STEPIE = 11;
  localparam int B_STOPC  = 10;
  localparam int B_STOPT  = 9;
  localparam int B_V      = 5;
  localparam int B_NMIP   = 3;
  localparam int B_STEP   = 2;

  typedef enum logic [2:0] {
    CZ_NONE    = 3'd0,
    CZ_EBREAK  = 3'd1,
    CZ_TRIGGER = 3'd2,
    CZ_HALTREQ = 3'd3,
    CZ_STEP    = 3'd4,
    CZ_RSTHALT = 3'd5,
    CZ_GROUP   = 3'd6,
    CZ_OTHER   = 3'd7
  } cause_e;

  // Source vector index 0 is the highest priority.
  localparam int NUM_SRC = 7;
  localparam int S_CRIT = 0;
  localparam int S_RST  = 1;
  localparam int S_GRP  = 2;
  localparam int S_REQ  = 3;
  localparam int S_TRIG = 4;
  localparam int S_EBRK = 5;
  localparam int S_STEP = 6;

  typedef struct packed {
    logic vs;
    logic vu;
    logic m;
    logic s;
    logic u;
  } ebk_en_t;

  function automatic cause_e src_cause(input int idx);
    case (idx)
      S_CRIT:  return CZ_OTHER;
      S_RST:   return CZ_RSTHALT;
      S_GRP:   return CZ_GROUP;
      S_REQ:   return CZ_HALTREQ;
      S_TRIG:  return CZ_TRIGGER;
      S_EBRK:  return CZ_EBREAK;
      default: return CZ_STEP;
    endcase
  endfunction

  function automatic logic ebreak_hits(input logic [1:0] priv, input logic virt,
                                       input ebk_en_t en);
    case (priv)
      2'd3:    return en.m;
      2'd1:    return virt ? en.vs : en.s;
      2'd0:    return virt ? en.vu : en.u;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [1:0] legal_priv(input logic [1:0] wr, input bit has_s,
                                            input bit has_u);
    case (wr)
      2'd1:    return has_s ? 2'd1 : 2'd3;
      2'd0:    return has_u ? 2'd0 : 2'd3;
      default: return 2'd3;
    endcase
  endfunction

endpackage

// File: rtl/dbg_cause_arb.sv
module dbg_cause_arb
  import dbg_ctrl_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  output logic               fire_o,
  output cause_e             cause_o,
  output logic [NUM_SRC-1:0] grant_o
);

  // isolate lowest set bit: index 0 carries the top priority
  assign grant_o = src_i & (~src_i + NUM_SRC'(1));
  assign fire_o  = |src_i;

  always_comb begin
    cause_o = CZ_NONE;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (grant_o[i]) cause_o = src_cause(i);
    end
  end

  // R2
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));

  // R2
  grant_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |-> ((grant_o & ~src_i) == '0) && (grant_o != '0));

endmodule

// File: rtl/dbg_csr_regs.sv
module dbg_csr_regs
  import dbg_ctrl_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int IALIGN = 32,
  parameter bit HAS_S  = 1'b1,
  parameter bit HAS_U  = 1'b1,
  parameter bit HAS_V  = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dctl_we_i,
  input  logic            dpc_we_i,
  input  logic [XLEN-1:0] wdata_i,
  input  logic            enter_i,
  input  cause_e          enter_cause_i,
  input  logic [1:0]      enter_priv_i,
  input  logic            enter_virt_i,
  input  logic [XLEN-1:0] enter_pc_i,
  input  logic            nmi_pend_i,
  output logic [31:0]     dctl_o,
  output logic [XLEN-1:0] dpc_o,
  output logic            cetrig_o,
  output ebk_en_t         ebk_o,
  output logic            stepie_o,
  output logic            stopcount_o,
  output logic            stoptime_o,
  output logic            step_o,
  output cause_e          cause_o,
  output logic [1:0]      priv_o,
  output logic            virt_o
);

  localparam logic [XLEN-1:0] PC_MASK = (IALIGN == 32) ? ~XLEN'(3) : ~XLEN'(1);

  logic            cetrig_q, stepie_q, stopc_q, stopt_q, step_q, virt_q;
  ebk_en_t         ebk_q;
  cause_e          cause_q;
  logic [1:0]      priv_q;
  logic [XLEN-1:0] dpc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cetrig_q <= 1'b0;
      stepie_q <= 1'b0;
      stopc_q  <= 1'b0;
      stopt_q  <= 1'b0;
      step_q   <= 1'b0;
      virt_q   <= 1'b0;
      ebk_q    <= '0;
      cause_q  <= CZ_NONE;
      priv_q   <= 2'd3;
      dpc_q    <= '0;
    end else begin
      if (dctl_we_i) begin
        cetrig_q <= wdata_i[B_CETRIG];
        ebk_q.vs <= HAS_V && wdata_i[B_EB_VS];
        ebk_q.vu <= HAS_V && wdata_i[B_EB_VU];
        ebk_q.m  <= wdata_i[B_EB_M];
        ebk_q.s  <= HAS_S && wdata_i[B_EB_S];
        ebk_q.u  <= HAS_U && wdata_i[B_EB_U];
        stepie_q <= wdata_i[B_STEPIE];
        stopc_q  <= wdata_i[B_STOPC];
        stopt_q  <= wdata_i[B_STOPT];
        step_q   <= wdata_i[B_STEP];
        virt_q   <= HAS_V && wdata_i[B_V];
        priv_q   <= legal_priv(wdata_i[1:0], HAS_S, HAS_U);
      end
      if (dpc_we_i) dpc_q <= wdata_i & PC_MASK;
      // hardware capture wins over a same-cycle debugger write
      if (enter_i) begin
        cause_q <= enter_cause_i;
        priv_q  <= enter_priv_i;
        virt_q  <= HAS_V && enter_virt_i;
        dpc_q   <= enter_pc_i & PC_MASK;
      end
    end
  end

  always_comb begin
    dctl_o             = '0;
    dctl_o[31:28]      = DBG_VERSION;
    dctl_o[26:24]      = 3'd0;
    dctl_o[B_CETRIG]   = cetrig_q;
    dctl_o[B_EB_VS]    = ebk_q.vs;
    dctl_o[B_EB_VU]    = ebk_q.vu;
    dctl_o[B_EB_M]     = ebk_q.m;
    dctl_o[B_EB_S]     = ebk_q.s;
    dctl_o[B_EB_U]     = ebk_q.u;
    dctl_o[B_STEPIE]   = stepie_q;
    dctl_o[B_STOPC]    = stopc_q;
    dctl_o[B_STOPT]    = stopt_q;
    dctl_o[8:6]        = cause_q;
    dctl_o[B_V]        = virt_q;
    dctl_o[B_NMIP]     = nmi_pend_i;
    dctl_o[B_STEP]     = step_q;
    dctl_o[1:0]        = priv_q;
  end

  assign dpc_o       = dpc_q;
  assign cetrig_o    = cetrig_q;
  assign ebk_o       = ebk_q;
  assign stepie_o    = stepie_q;
  assign stopcount_o = stopc_q;
  assign stoptime_o  = stopt_q;
  assign step_o      = step_q;
  assign cause_o     = cause_q;
  assign priv_o      = priv_q;
  assign virt_o      = virt_q;

  // R11
  prv_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dctl_we_i && !enter_i) |=> (priv_q != 2'd2));

  // R12
  dpc_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dpc_we_i || enter_i) |=> ((dpc_q & ~PC_MASK) == '0));

  // R13
  cause_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dctl_we_i && !enter_i) |=> $stable(cause_q));

endmodule

// File: rtl/dbg_mode_ctrl.sv
module dbg_mode_ctrl
  import dbg_ctrl_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int IALIGN = 32,
  parameter bit HAS_S  = 1'b1,
  parameter bit HAS_U  = 1'b1,
  parameter bit HAS_V  = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            halt_crit_i,
  input  logic            halt_rst_i,
  input  logic            halt_grp_i,
  input  logic            halt_req_i,
  input  logic            trig_i,
  input  logic            ebreak_i,
  input  logic            step_done_i,
  input  logic [1:0]      cur_priv_i,
  input  logic            cur_virt_i,
  input  logic [XLEN-1:0] next_pc_i,
  input  logic            nmi_pend_i,
  input  logic            resume_req_i,
  input  logic            csr_we_i,
  input  logic [11:0]     csr_addr_i,
  input  logic [XLEN-1:0] csr_wdata_i,
  output logic [XLEN-1:0] csr_rdata_o,
  output logic            debug_mode_o,
  output logic            resume_o,
  output logic [XLEN-1:0] resume_pc_o,
  output logic [1:0]      resume_priv_o,
  output logic            resume_virt_o,
  output logic            crit_err_o,
  output logic            ebreak_exc_o,
  output logic            irq_mask_o,
  output logic            stop_count_o,
  output logic            stop_time_o
);

  localparam logic [XLEN-1:0] PC_MASK = (IALIGN == 32) ? ~XLEN'(3) : ~XLEN'(1);

  logic               dbg_q, resume_q;
  logic               dctl_we, dpc_we;
  logic [31:0]        dctl_rd;
  logic [XLEN-1:0]    dpc_rd;
  logic               cetrig, stepie, stopc, stopt, step_en, virt_f;
  ebk_en_t            ebk_en;
  cause_e             cause_f, arb_cause;
  logic [1:0]         priv_f;
  logic               ebk_ok;
  logic [NUM_SRC-1:0] src_raw, arb_src, arb_grant;
  logic               enter, crit_reentry, leave;

  assign dctl_we = csr_we_i && (csr_addr_i == ADDR_DCTL);
  assign dpc_we  = csr_we_i && (csr_addr_i == ADDR_DPC);

  assign ebk_ok = ebreak_hits(cur_priv_i, cur_virt_i, ebk_en);

  always_comb begin
    src_raw         = '0;
    src_raw[S_CRIT] = halt_crit_i && cetrig;
    src_raw[S_RST]  = halt_rst_i;
    src_raw[S_GRP]  = halt_grp_i;
    src_raw[S_REQ]  = halt_req_i;
    src_raw[S_TRIG] = trig_i;
    src_raw[S_EBRK] = ebreak_i && ebk_ok;
    src_raw[S_STEP] = step_done_i && step_en;
  end

  // halt sources are only heard while the hart runs
  assign arb_src = dbg_q ? '0 : src_raw;

  dbg_cause_arb i_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .src_i   (arb_src),
    .fire_o  (enter),
    .cause_o (arb_cause),
    .grant_o (arb_grant)
  );

  dbg_csr_regs #(
    .XLEN   (XLEN),
    .IALIGN (IALIGN),
    .HAS_S  (HAS_S),
    .HAS_U  (HAS_U),
    .HAS_V  (HAS_V)
  ) i_regs (
    .clk           (clk),
    .rst_n         (rst_n),
    .dctl_we_i     (dctl_we),
    .dpc_we_i      (dpc_we),
    .wdata_i       (csr_wdata_i),
    .enter_i       (enter),
    .enter_cause_i (arb_cause),
    .enter_priv_i  (cur_priv_i),
    .enter_virt_i  (cur_virt_i),
    .enter_pc_i    (next_pc_i),
    .nmi_pend_i    (nmi_pend_i),
    .dctl_o        (dctl_rd),
    .dpc_o         (dpc_rd),
    .cetrig_o      (cetrig),
    .ebk_o         (ebk_en),
    .stepie_o      (stepie),
    .stopcount_o   (stopc),
    .stoptime_o    (stopt),
    .step_o        (step_en),
    .cause_o       (cause_f),
    .priv_o        (priv_f),
    .virt_o        (virt_f)
  );

  assign crit_reentry = dbg_q && resume_req_i && (cause_f == CZ_OTHER) && cetrig;
  assign leave        = dbg_q && resume_req_i && !crit_reentry;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dbg_q    <= 1'b0;
      resume_q <= 1'b0;
    end else begin
      resume_q <= leave;
      if (enter)      dbg_q <= 1'b1;
      else if (leave) dbg_q <= 1'b0;
    end
  end

  always_comb begin
    case (csr_addr_i)
      ADDR_DCTL: csr_rdata_o = XLEN'(dctl_rd);
      ADDR_DPC:  csr_rdata_o = dpc_rd;
      default:   csr_rdata_o = '0;
    endcase
  end

  assign debug_mode_o  = dbg_q;
  assign resume_o      = resume_q;
  assign resume_pc_o   = dpc_rd;
  assign resume_priv_o = priv_f;
  assign resume_virt_o = virt_f;
  assign crit_err_o    = halt_crit_i && !cetrig && !dbg_q;
  assign ebreak_exc_o  = ebreak_i && !ebk_ok && !dbg_q;
  assign irq_mask_o    = dbg_q || (step_en && !stepie);
  assign stop_count_o  = dbg_q && stopc;
  assign stop_time_o   = dbg_q && stopt;

  // R3
  crit_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dbg_q && halt_crit_i && cetrig) |=> (debug_mode_o && cause_f == CZ_OTHER));

  // R5
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enter |=> (priv_f == $past(cur_priv_i)) && (dpc_rd == ($past(next_pc_i) & PC_MASK)));

  // R6
  resume_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resume_o |-> !debug_mode_o);

  // R7
  crit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    crit_reentry |=> (debug_mode_o && !resume_o));

  // R14
  halt_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_q && !resume_req_i) |=> (debug_mode_o && $stable(cause_f)));

endmodule

// File: tb/test_dbg_mode_ctrl.sv
`timescale 1ns/1ps
module test_dbg_mode_ctrl;

  localparam int XLEN = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            halt_crit_i = 0, halt_rst_i = 0, halt_grp_i = 0, halt_req_i = 0;
  logic            trig_i = 0, ebreak_i = 0, step_done_i = 0;
  logic [1:0]      cur_priv_i = 2'd3;
  logic            cur_virt_i = 0;
  logic [XLEN-1:0] next_pc_i = '0;
  logic            nmi_pend_i = 0, resume_req_i = 0, csr_we_i = 0;
  logic [11:0]     csr_addr_i = 12'h7B0;
  logic [XLEN-1:0] csr_wdata_i = '0;
  logic [XLEN-1:0] csr_rdata_o, resume_pc_o;
  logic            debug_mode_o, resume_o, resume_virt_o, crit_err_o, ebreak_exc_o;
  logic            irq_mask_o, stop_count_o, stop_time_o;
  logic [1:0]      resume_priv_o;

  dbg_mode_ctrl #(.XLEN(XLEN)) i_dbg_mode_ctrl (.*);

  always #5 clk = ~clk;

  localparam int O_DBG = 0, O_RES = 1, O_RPC = 2, O_RPRIV = 3, O_RVIRT = 4, O_CRIT = 5,
                 O_EBX = 6, O_IRQM = 7, O_STOPC = 8, O_STOPT = 9, O_RDATA = 10,
                 O_CAUSE = 11, O_EXTC = 12;

  typedef struct {
    string       req;
    int          obs;
    logic [63:0] exp;
  } item_t;

  item_t sbq[$];
  int    n_checks = 0;
  int    n_errors = 0;
  bit    done = 0;

  function automatic logic [63:0] observe(input int obs);
    case (obs)
      O_DBG:   return 64'(debug_mode_o);
      O_RES:   return 64'(resume_o);
      O_RPC:   return 64'(resume_pc_o);
      O_RPRIV: return 64'(resume_priv_o);
      O_RVIRT: return 64'(resume_virt_o);
      O_CRIT:  return 64'(crit_err_o);
      O_EBX:   return 64'(ebreak_exc_o);
      O_IRQM:  return 64'(irq_mask_o);
      O_STOPC: return 64'(stop_count_o);
      O_STOPT: return 64'(stop_time_o);
      O_RDATA: return 64'(csr_rdata_o);
      O_CAUSE: return 64'(csr_rdata_o[8:6]);
      default: return 64'(csr_rdata_o[26:24]);
    endcase
  endfunction

  // monitor: compare queued expectations shortly after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #3;
      while (sbq.size() > 0) begin
        item_t it;
        logic [63:0] act;
        it  = sbq.pop_front();
        act = observe(it.obs);
        n_checks++;
        if (act !== it.exp) begin
          n_errors++;
          $display("FAIL %s obs=%0d actual=0x%0h expected=0x%0h", it.req, it.obs, act, it.exp);
        end
      end
    end
  end

  task automatic expect_val(input string req, input int obs, input logic [63:0] exp);
    item_t it;
    it.req = req; it.obs = obs; it.exp = exp;
    sbq.push_back(it);
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic clear_src();
    halt_crit_i = 0; halt_rst_i = 0; halt_grp_i = 0; halt_req_i = 0;
    trig_i = 0; ebreak_i = 0; step_done_i = 0;
  endtask

  task automatic wr_csr(input logic [11:0] a, input logic [31:0] d);
    csr_we_i = 1; csr_addr_i = a; csr_wdata_i = d;
    tick();
    csr_we_i = 0; csr_addr_i = 12'h7B0;
  endtask

  task automatic rd_expect(input string req, input logic [11:0] a, input logic [31:0] e);
    csr_addr_i = a;
    expect_val(req, O_RDATA, 64'(e));
    tick();
    csr_addr_i = 12'h7B0;
  endtask

  task automatic do_resume(input string req);
    resume_req_i = 1;
    expect_val(req, O_DBG, 0);
    expect_val(req, O_RES, 1);
    tick();
    resume_req_i = 0;
    expect_val(req, O_RES, 0);
    tick();
  endtask

  // ranking written as a chain: m = {rst, grp, req, trig, ebreak, step}
  function automatic logic [2:0] rank_cause(input logic [5:0] m);
    if (m[5]) return 3'd5;
    if (m[4]) return 3'd6;
    if (m[3]) return 3'd3;
    if (m[2]) return 3'd2;
    if (m[1]) return 3'd1;
    return 3'd4;
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    logic [5:0] pats [6];
    pats = '{6'b111111, 6'b011111, 6'b001101, 6'b000111, 6'b000011, 6'b000001};

    repeat (3) tick();
    rst_n = 1;
    // R1 reset state
    expect_val("R1", O_DBG, 0);
    expect_val("R1", O_RES, 0);
    expect_val("R1", O_IRQM, 0);
    expect_val("R1", O_RDATA, 64'h4000_0003);
    tick();

    // R13 writable fields read back, RO fields keep their values
    wr_csr(12'h7B0, 32'hFFFF_FFFF);
    rd_expect("R13", 12'h7B0, 32'h4000_0000 | (32'h1 << 19) | (32'h3 << 16) | (32'h1 << 15)
              | (32'h3 << 12) | (32'h7 << 9) | 32'h20 | 32'h4 | 32'h3);
    expect_val("R9 stepie set", O_IRQM, 0);
    tick();
    wr_csr(12'h7B0, 32'h0000_0004);
    expect_val("R9 step no stepie", O_IRQM, 1);
    rd_expect("R13", 12'h7B0, 32'h4000_0004);

    // R11 privilege legalization
    wr_csr(12'h7B0, 32'h2);
    rd_expect("R11", 12'h7B0, 32'h4000_0003);
    wr_csr(12'h7B0, 32'h1);
    rd_expect("R11", 12'h7B0, 32'h4000_0001);

    // R10 live NMI pending
    nmi_pend_i = 1;
    rd_expect("R10", 12'h7B0, 32'h4000_0009);
    nmi_pend_i = 0;
    rd_expect("R10", 12'h7B0, 32'h4000_0001);

    // R12 debug PC alignment
    wr_csr(12'h7B1, 32'h0000_1237);
    rd_expect("R12", 12'h7B1, 32'h0000_1234);
    wr_csr(12'h7B1, 32'h8000_0002);
    rd_expect("R12", 12'h7B1, 32'h8000_0000);

    // R2 ranking across simultaneous sources (ebreakm and step set)
    wr_csr(12'h7B0, 32'h0000_8004);
    cur_priv_i = 2'd3; cur_virt_i = 0; next_pc_i = 32'h0000_0100;
    foreach (pats[i]) begin
      halt_rst_i = pats[i][5]; halt_grp_i = pats[i][4]; halt_req_i = pats[i][3];
      trig_i = pats[i][2]; ebreak_i = pats[i][1]; step_done_i = pats[i][0];
      expect_val("R2", O_DBG, 1);
      expect_val("R2", O_CAUSE, 64'(rank_cause(pats[i])));
      tick();
      clear_src();
      resume_req_i = 1;
      expect_val("R6", O_RPC, 64'h100);
      expect_val("R6", O_RES, 1);
      tick();
      resume_req_i = 0;
      tick();
    end

    // R5 capture of privilege, virtualization and PC
    cur_priv_i = 2'd1; cur_virt_i = 1; next_pc_i = 32'h0000_4444;
    halt_req_i = 1;
    expect_val("R5", O_RDATA, 64'h4000_80E5);
    tick();
    clear_src();
    rd_expect("R5", 12'h7B1, 32'h0000_4444);

    // R14 sources ignored in Debug Mode; freeze controls
    halt_rst_i = 1; trig_i = 1;
    expect_val("R14", O_DBG, 1);
    expect_val("R14", O_CAUSE, 3);
    expect_val("R14", O_STOPC, 0);
    tick();
    clear_src();
    wr_csr(12'h7B0, 32'h0000_0621);
    expect_val("R14", O_STOPC, 1);
    expect_val("R14", O_STOPT, 1);
    expect_val("R14", O_CAUSE, 3);
    tick();

    // R6 resume values
    resume_req_i = 1;
    expect_val("R6", O_DBG, 0);
    expect_val("R6", O_RES, 1);
    expect_val("R6", O_RPC, 64'h4444);
    expect_val("R6", O_RPRIV, 1);
    expect_val("R6", O_RVIRT, 1);
    expect_val("R14", O_STOPC, 0);
    expect_val("R14", O_STOPT, 0);
    tick();
    resume_req_i = 0;
    expect_val("R6", O_RES, 0);
    tick();

    // R8 per-mode ebreak enables (only U enabled)
    wr_csr(12'h7B0, 32'h0000_1000);
    cur_priv_i = 2'd3; cur_virt_i = 0; ebreak_i = 1;
    expect_val("R8 M off", O_EBX, 1);
    expect_val("R8 M off", O_DBG, 0);
    tick();
    cur_priv_i = 2'd0;
    expect_val("R8 U on", O_DBG, 1);
    expect_val("R8 U on", O_CAUSE, 1);
    expect_val("R8 U on", O_EBX, 0);
    tick();
    clear_src();
    do_resume("R8");
    cur_priv_i = 2'd1; cur_virt_i = 1; ebreak_i = 1;
    expect_val("R8 VS off", O_EBX, 1);
    expect_val("R8 VS off", O_DBG, 0);
    tick();
    clear_src();
    cur_priv_i = 2'd3; cur_virt_i = 0;

    // R9 step halt and interrupt mask
    wr_csr(12'h7B0, 32'h0000_0004);
    step_done_i = 1;
    expect_val("R9", O_DBG, 1);
    expect_val("R9", O_CAUSE, 4);
    expect_val("R9", O_IRQM, 1);
    tick();
    clear_src();
    wr_csr(12'h7B0, 32'h0000_0807);
    do_resume("R9");
    expect_val("R9 stepie", O_IRQM, 0);
    expect_val("R9 stepie", O_DBG, 0);
    tick();

    // R3 critical error with cetrig outranks all
    wr_csr(12'h7B0, 32'h0008_0003);
    halt_crit_i = 1; halt_rst_i = 1; halt_req_i = 1;
    expect_val("R3", O_DBG, 1);
    expect_val("R3", O_CAUSE, 7);
    expect_val("R3", O_EXTC, 0);
    expect_val("R3", O_CRIT, 0);
    tick();
    clear_src();

    // R7 resume with cetrig still set stays halted
    resume_req_i = 1;
    expect_val("R7", O_DBG, 1);
    expect_val("R7", O_RES, 0);
    tick();
    resume_req_i = 0;
    tick();
    wr_csr(12'h7B0, 32'h0000_0003);
    expect_val("R13 cause kept", O_CAUSE, 7);
    tick();
    do_resume("R7");

    // R4 critical error without cetrig
    halt_crit_i = 1;
    expect_val("R4", O_CRIT, 1);
    expect_val("R4", O_DBG, 0);
    tick();
    clear_src();
    expect_val("R4", O_CRIT, 0);
    expect_val("R4", O_DBG, 0);
    tick();
    tick();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule